// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose read path is pipelined and whose write data lags its address by the same amount. A read and a write can therefore share the data bus on back-to-back cycles with no idle slot. Each word is 36 bits wide and is split into four 9-bit lanes. A lane holds eight data bits and one parity bit, and each lane has its own active-low write select. The memory depth is a parameter, sized small for simulation.

A controller issues accesses on rising clock edges. A load (`adv_ld` low with all three chip enables active) starts an access at a new address. Advance cycles (`adv_ld` high) step a two-bit burst counter in linear or interleaved order, chosen by the static `mode` strap. An active-low clock enable freezes the whole pipeline. The bidirectional bus appears as separate `dq_i`, `dq_o` and a drive enable `dq_oe`, which an outer tristate buffer would use.

Top module: `zbt_sram`

## Requirements
- R1: With `cke_n` high a clock edge is ignored: no command is captured, no memory lane is written, and `dq_o`/`dq_oe` keep their values (apart from the asynchronous effect of `oe_n`).
- R2: A load cycle selects the device only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect: nothing is read or written, and `dq_oe` stays low for that slot.
- R3: A read command captured at enabled edge N places the word on `dq_o`, with `dq_oe` high (when `oe_n` is low), right after enabled edge N+1.
- R4: A load with `we_n` low starts a write. The write data is taken from `dq_i` at the second enabled edge after the address edge. `bw_n[i]` low writes lane i, which is bits [9i+8:9i] with bit 9i+8 as parity. Lanes whose select is high keep their contents.
- R5: An advance cycle (`adv_ld`=1) after a load continues the same operation type. It ignores the chip enables, samples `bw_n` again, and keeps address bits above bit 1 fixed.
- R6: With `mode`=0 the burst order is linear: low address bits = (start + beat count) mod 4, wrapping after four beats.
- R7: With `mode`=1 the burst order is interleaved: low address bits = start XOR beat count.
- R8: An advance cycle that follows a deselect performs no access.
- R9: `dq_oe` is low during the data slot of a write, in the first slot after a deselect, and for as long as the device is deselected.
- R10: `oe_n` high forces `dq_oe` low at once, without waiting for a clock.
- R11: A read issued on the cycle after a write to the same address returns the new write data, with no idle cycle between them. Lanes not written return their old contents.
- R12: A synchronous reset (`rst` high) leaves no access in flight and drives `dq_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Active-low clock enable; high stalls the pipeline |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Active-low write command, sampled on load cycles |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| bw_n | input | LANES | Active-low per-lane write selects |
| mode | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable for the outer tristate buffer |

## Verification
The in-line assertions check on every clock that a stall freezes the captured command, that deselects and advances after a deselect produce no access, and that a burst keeps its upper address bits and steps by one in linear order. They also check that a read always drives the bus one enabled edge later, and that the bus never drives during a write data slot or while `oe_n` is high. Only the bench scenarios can show that the stored data is correct: lane-masked writes, interleaved burst sequences, forwarding of a write still in flight to the next read, and write data that lands correctly when stalls fall inside its window. For this the bench compares each output slot against its own model of the memory and burst order.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_lane_ram.sv
`timescale 1ns/1ps
// One byte lane: simple dual-port storage with a registered read and a
// bypass register for a write that commits on the same edge as the read.
module zbt_lane_ram #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          en,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  input  logic          fwd,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;
  logic [W-1:0] byp_q;
  logic         byp_sel_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (wr) mem[waddr] <= wdata;
      rd_q      <= mem[raddr];
      byp_q     <= wdata;
      byp_sel_q <= fwd;
    end
  end

  assign rdata = byp_sel_q ? byp_q : rd_q;
endmodule

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
// Command decode and burst address generation (first pipeline stage).
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             we_n,
  input  logic             adv_ld,
  input  logic             mode,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_bw_n
);
  logic          act_q, wr_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          act_d, wr_d, sel;
  logic [AW-1:0] base_d;
  logic [1:0]    cnt_d, low_d;

  always_comb begin
    sel    = !ce1_n && ce2 && !ce3_n;
    act_d  = act_q;
    wr_d   = wr_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (!adv_ld) begin
      act_d = sel;
      if (sel) begin
        wr_d   = !we_n;
        base_d = addr;
        cnt_d  = 2'd0;
      end
    end else if (act_q) begin
      cnt_d = cnt_q + 2'd1;
    end
    low_d = mode ? (base_d[1:0] ^ cnt_d) : (base_d[1:0] + cnt_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_bw_n <= '1;
    end else if (en) begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      s1_op   <= act_d ? (wr_d ? OP_WRITE : OP_READ) : OP_IDLE;
      s1_addr <= {base_d[AW-1:2], low_d};
      s1_bw_n <= bw_n;
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(s1_op) && $stable(s1_addr)));
  // R2
  desel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) |=> (s1_op == OP_IDLE));
  // R8
  dead_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (en && adv_ld && !act_q) |=> (s1_op == OP_IDLE));
  // R5
  burst_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (en && adv_ld && act_q) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));
  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && adv_ld && act_q && !mode) |=> (s1_addr[1:0] == 2'($past(s1_addr[1:0]) + 2'd1)));
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = zbt_pkg::LANES,
  parameter int LANE_W = zbt_pkg::LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    we_n,
  input  logic                    adv_ld,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    mode,
  input  logic [AW-1:0]           addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);
  logic             en;
  op_e              s1_op, s2_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_bw_n, s2_bw_n;
  logic             rd_vld_q;

  assign en = !cke_n;

  zbt_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk, .rst, .en, .ce1_n, .ce2, .ce3_n, .we_n, .adv_ld, .mode, .bw_n, .addr,
    .s1_op, .s1_addr, .s1_bw_n
  );

  // Second stage: read data launch and write data slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_op    <= OP_IDLE;
      s2_addr  <= '0;
      s2_bw_n  <= '1;
      rd_vld_q <= 1'b0;
    end else if (en) begin
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_bw_n  <= s1_bw_n;
      rd_vld_q <= (s1_op == OP_READ);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic wr_l, fwd_l;
    assign wr_l  = (s2_op == OP_WRITE) && !s2_bw_n[l];
    assign fwd_l = wr_l && (s1_op == OP_READ) && (s2_addr == s1_addr);
    zbt_lane_ram #(.AW(AW), .W(LANE_W)) u_ram (
      .clk, .en, .wr(wr_l), .waddr(s2_addr),
      .wdata(dq_i[l*LANE_W +: LANE_W]), .raddr(s1_addr), .fwd(fwd_l),
      .rdata(dq_o[l*LANE_W +: LANE_W])
    );
  end

  assign dq_oe = rd_vld_q && !oe_n;

  // R9
  wr_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_op == OP_WRITE) |-> !dq_oe);
  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (en && s1_op == OP_READ && !oe_n) |=> (dq_oe || oe_n));
  // R10
  oe_mask_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);
  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !dq_oe);
endmodule

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cke_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic          we_n = 1'b1, adv_ld = 1'b0, mode = 1'b0, oe_n = 1'b0;
  logic [LN-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  always #2.5 clk = ~clk;

  zbt_sram #(.AW(AW), .LANES(LN), .LANE_W(LW)) u0 (
    .clk, .rst, .cke_n, .ce1_n, .ce2, .ce3_n, .we_n, .adv_ld, .bw_n, .mode,
    .addr, .oe_n, .dq_i, .dq_o, .dq_oe
  );

  int nvec = 0, nfail = 0;
  bit done = 1'b0, run = 1'b0, edge_en = 1'b0, last_en = 1'b0;

  // Expected-item scoreboard queues (one entry per output slot)
  bit            q_rd[$];
  logic [DW-1:0] q_dat[$];
  string         q_tag[$];

  // Bench pipeline bookkeeping
  bit            cap_rd = 0, cap_wr = 0, iss_rd = 0, iss_wr = 0, dph_wr = 0;
  logic [DW-1:0] cap_dat = '0, iss_dat = '0, dph_dat = '0;
  string         cap_tag = "R12", iss_tag = "R12";

  // Reference model
  logic [DW-1:0] mm [1 << AW];
  bit            m_act = 0, m_wr = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            last_rd = 0;
  logic [DW-1:0] last_dat = '0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  // One clock of stimulus. Pushes the item whose output slot follows this edge.
  task automatic step(input bit stall, input bit [2:0] ce, input bit wen, input bit adv,
                      input bit [3:0] bw, input logic [AW-1:0] a, input bit oen, input string tag);
    logic [1:0]    lo;
    logic [AW-1:0] ea;
    logic [DW-1:0] wd;
    @(posedge clk); #1;
    if (last_en) begin
      q_rd.push_back(cap_rd); q_dat.push_back(cap_dat); q_tag.push_back(cap_tag);
      dph_wr = cap_wr; dph_dat = cap_dat;
      cap_rd = iss_rd; cap_wr = iss_wr; cap_dat = iss_dat; cap_tag = iss_tag;
    end
    oe_n = oen;
    if (stall) begin
      // R1: garbage on every input during a stalled edge
      cke_n = 1'b1;
      {ce1_n, ce2, ce3_n} = 3'($urandom);
      we_n = 1'($urandom); adv_ld = 1'($urandom);
      bw_n = 4'($urandom); addr = AW'($urandom); dq_i = rnd36();
      last_en = 1'b0;
    end else begin
      cke_n = 1'b0;
      {ce1_n, ce2, ce3_n} = ce;
      we_n = wen; adv_ld = adv; bw_n = bw; addr = a;
      dq_i = dph_wr ? dph_dat : rnd36();
      if (!adv) begin
        if (ce == 3'b010) begin
          m_act = 1; m_wr = !wen; m_base = a; m_cnt = 2'd0;
        end else m_act = 0;
      end else if (m_act) m_cnt = m_cnt + 2'd1;
      iss_rd = 0; iss_wr = 0; iss_dat = '0; iss_tag = tag;
      if (m_act) begin
        lo = mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        ea = {m_base[AW-1:2], lo};
        if (m_wr) begin
          wd = rnd36();
          for (int l = 0; l < LN; l++)
            if (!bw[l]) mm[ea][l*LW +: LW] = wd[l*LW +: LW];
          iss_wr = 1; iss_dat = wd;
        end else begin
          iss_rd = 1; iss_dat = mm[ea];
        end
      end
      last_en = 1'b1;
    end
  endtask

  task automatic rd_ld(input logic [AW-1:0] a, input string t); step(0, 3'b010, 1, 0, 4'hF, a, 0, t); endtask
  task automatic wr_ld(input logic [AW-1:0] a, input bit [3:0] bw, input string t); step(0, 3'b010, 0, 0, bw, a, 0, t); endtask
  task automatic adv(input bit [3:0] bw, input string t); step(0, 3'b101, 1, 1, bw, '0, 0, t); endtask
  task automatic dsel(input string t); step(0, 3'b101, 1, 0, 4'hF, '0, 0, t); endtask
  task automatic stl(input string t); step(1, 3'b000, 1, 0, 4'hF, '0, 0, t); endtask

  // Monitor: pops one expected slot per enabled edge, checks hold on stalled edges
  always @(posedge clk) edge_en = !cke_n && !rst;

  always @(negedge clk) begin
    bit exp_oe;
    string t;
    if (run) begin
      if (edge_en) begin
        if (q_rd.size() > 0) begin
          last_rd = q_rd.pop_front(); last_dat = q_dat.pop_front(); t = q_tag.pop_front();
          if (oe_n) t = "R10";
          exp_oe = last_rd && !oe_n;
          chk(dq_oe == exp_oe, t, DW'(dq_oe), DW'(exp_oe));
          if (exp_oe) chk(dq_o == last_dat, t, dq_o, last_dat);
        end
      end else begin
        exp_oe = last_rd && !oe_n;
        chk(dq_oe == exp_oe, "R1", DW'(dq_oe), DW'(exp_oe));
        if (exp_oe) chk(dq_o == last_dat, "R1", dq_o, last_dat);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(dq_oe == 1'b0, "R12", DW'(dq_oe), '0);
    run = 1'b1;

    // R4: full-word fill of every location
    for (int a = 0; a < (1 << AW); a++) wr_ld(AW'(a), 4'h0, "R4");
    dsel("R9");
    // R3: back-to-back single reads
    rd_ld(8'd0, "R3"); rd_ld(8'd5, "R3"); rd_ld(8'd255, "R3"); rd_ld(8'd128, "R3"); rd_ld(8'd77, "R3");
    // R9: deselect, then a read right after it
    dsel("R9"); dsel("R9"); rd_ld(8'd6, "R9");
    // R2: loads with wrong enable combinations, then verify nothing was written
    step(0, 3'b110, 0, 0, 4'h0, 8'd5, 0, "R2");
    step(0, 3'b000, 0, 0, 4'h0, 8'd5, 0, "R2");
    step(0, 3'b011, 1, 0, 4'hF, 8'd5, 0, "R2");
    dsel("R2"); rd_ld(8'd5, "R2");
    // R4: lane-masked write (lanes 0 and 2 written)
    wr_ld(8'd9, 4'b1010, "R4"); dsel("R4"); dsel("R4"); rd_ld(8'd9, "R4");
    // R11: read immediately after write, alternating bus direction (R9)
    wr_ld(8'd20, 4'h0, "R11"); rd_ld(8'd20, "R11");
    wr_ld(8'd21, 4'b0110, "R11"); rd_ld(8'd21, "R11"); rd_ld(8'd20, "R11");
    wr_ld(8'd22, 4'h0, "R11"); dsel("R11"); rd_ld(8'd22, "R11");
    // R6: linear read burst, five beats wrap around
    rd_ld(8'h13, "R6"); adv(4'hF, "R6"); adv(4'hF, "R6"); adv(4'hF, "R6"); adv(4'hF, "R6");
    // R5: write burst with per-beat lane selects, then read it back
    wr_ld(8'h42, 4'h0, "R5"); adv(4'b0011, "R5"); adv(4'b1100, "R5"); adv(4'h0, "R5");
    rd_ld(8'h42, "R5"); adv(4'hF, "R5"); adv(4'hF, "R5"); adv(4'hF, "R5");
    // R8: advance after deselect does nothing
    wr_ld(8'd50, 4'h0, "R8"); dsel("R8"); step(0, 3'b010, 0, 1, 4'h0, 8'd51, 0, "R8");
    adv(4'h0, "R8"); rd_ld(8'd50, "R8"); rd_ld(8'd51, "R8"); rd_ld(8'd52, "R8");
    // R1: stalls inside a read burst and inside a write data window
    rd_ld(8'd100, "R1"); stl("R1"); stl("R1"); adv(4'hF, "R1"); stl("R1"); adv(4'hF, "R1");
    wr_ld(8'd101, 4'h0, "R1"); dsel("R1"); stl("R1"); stl("R1"); dsel("R1"); rd_ld(8'd101, "R1");
    // R7: interleaved order
    dsel("R7"); dsel("R7");
    mode = 1'b1;
    rd_ld(8'h61, "R7"); adv(4'hF, "R7"); adv(4'hF, "R7"); adv(4'hF, "R7");
    wr_ld(8'h8E, 4'h0, "R7"); adv(4'h0, "R7"); adv(4'h0, "R7"); adv(4'h0, "R7");
    rd_ld(8'h8C, "R7"); rd_ld(8'h8D, "R7"); rd_ld(8'h8E, "R7"); rd_ld(8'h8F, "R7");
    // R10: output enable masks an active read slot
    rd_ld(8'd30, "R10"); rd_ld(8'd31, "R10");
    step(0, 3'b101, 1, 0, 4'hF, '0, 1, "R10");
    dsel("R10");
    rd_ld(8'd32, "R10"); stl("R10");
    step(1, 3'b000, 1, 0, 4'hF, '0, 1, "R10");
    dsel("R10"); dsel("R10"); dsel("R10");
    @(posedge clk); #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule